// File: doc/BRIEF.md
# Speech Sample Fetch Sequencer

This block is the front end of a speech-sample playback path. A host places a sample number on `sample_num` and raises `start`. The sequencer then pulls five bytes, one at a time, from an external byte source. It asks for each byte by pulsing `drq` and reads the byte from `data_in`. The bytes arrive in this order:

1. the highest sample index stored in the library;
2. a filler byte;
3. the upper part of the sample's data address;
4. the lower part of the sample's data address;
5. a second filler byte.

From the two address bytes it forms a 17-bit byte address for the sample's first block header. It then offers that address to the downstream decoder through a valid/ready pair.

Every step waits a fixed number of clocks. Every data request is a pulse of fixed width. If the requested number is larger than the stored highest index, the sequence gives up and the block goes back to idle. The active-low `rst_n` input sends the block back to idle from any state. The active-low `busy_n` output tells the host when a new request may be issued.

Top module: `adpcm_fetch_seq`

## Requirements
- R1: While `rst_n` is low, the block is idle: `busy_n`=1, `drq`=0, `hdr_valid`=0 and `fetch_addr`=0.
- R2: A request is taken only on a clock edge where `start` is 1, `start` was 0 at the previous edge, the block is idle, and `rst_n` is high. A `start` held high through reset release, or raised while busy, has no effect.
- R3: `busy_n` is 1 exactly when the block is idle. It goes to 0 at the edge that takes a request.
- R4: The first rising edge of `drq` comes 71 clock edges after the edge that took the request. That is one setup edge plus a 70-clock wait.
- R5: The rising edges of `drq` come at intervals of 44, 28, 32, 44 and 36 clocks. Six requests are made in all.
- R6: Every `drq` pulse is high for exactly 21 clocks.
- R7: The byte on `data_in` at the second `drq` rise is taken as the highest index. If `sample_num` is greater than that byte (equal continues), the block is idle 21 clocks later and issues no third request.
- R8: The byte present at the fourth `drq` rise is the upper address byte H. The byte present at the fifth rise is the lower address byte L. The address offered is H*512 + L*2 + 1.
- R9: `hdr_valid` rises when the sixth `drq` pulse ends. While `hdr_ready` is 0 it stays high with `fetch_addr` unchanged. At the edge where `hdr_ready` is 1, the block returns to idle.
- R10: `sample_num` is captured at the edge that takes the request. Later changes to it do not affect the outcome.
- R11: Pulling `rst_n` low in the middle of a sequence ends it: `drq` drops and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; returns the block to idle |
| start | input | 1 | Request strobe, acted on at its rising edge |
| sample_num | input | 8 | Number of the sample to play |
| data_in | input | 8 | Byte from the external source |
| drq | output | 1 | Data request pulse |
| busy_n | output | 1 | High when idle |
| fetch_addr | output | 17 | Byte address of the first block header |
| hdr_valid | output | 1 | Address offered to the decoder |
| hdr_ready | input | 1 | Decoder accepts the address |

## Verification
Two events can fall in the same edge: the completion of the handoff (`hdr_valid` with `hdr_ready`) and a new rising edge of `start`. At that edge the block is not yet idle, so the new request must be refused.

The bench raises `start` in the very cycle it asserts `hdr_ready`. It then judges the outcome at the ports: `busy_n` must go high and stay high for several clocks, and `drq` must stay low.

A second collision is also exercised. The abort decision and the raising of the filler request happen at the same edge, and the bench judges this by the exact idle time and by the count of requests.

// File: rtl/adpcm_fetch_seq.sv
`timescale 1ns/1ps
module adpcm_fetch_seq #(
  parameter int AW = 17,
  parameter int DW = 8,
  parameter int SW = 8,
  parameter int CW = 7,
  parameter int T_START = 70,
  parameter int T_LAST = 44,
  parameter int T_DUM1 = 28,
  parameter int T_AHI = 32,
  parameter int T_ALO = 44,
  parameter int T_DUM2 = 36,
  parameter int T_DROP = 21,
  parameter int T_IDLE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] sample_num,
  input  logic [DW-1:0] data_in,
  output logic          drq,
  output logic          busy_n,
  output logic [AW-1:0] fetch_addr,
  output logic          hdr_valid,
  input  logic          hdr_ready
);
  localparam int HI_POS = DW + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_REQ0, S_LAST, S_DUM1, S_AHI, S_ALO, S_DUM2, S_DROP, S_HAND
  } st_t;

  st_t st, post_st;
  logic [CW-1:0] cnt, post_cnt;
  logic [SW-1:0] req_q;
  logic [AW-1:0] addr_q;
  logic drq_q, start_q;

  wire accept = start && !start_q && (st == S_IDLE);
  wire expire = (cnt == CW'(1));

  assign drq        = drq_q;
  assign busy_n     = (st == S_IDLE);
  assign hdr_valid  = (st == S_HAND);
  assign fetch_addr = addr_q;

  always_ff @(posedge clk) start_q <= start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; post_st <= S_IDLE;
      cnt <= CW'(T_IDLE); post_cnt <= CW'(T_IDLE);
      req_q <= '0; addr_q <= '0; drq_q <= 1'b0;
    end else if (accept) begin
      st <= S_START; cnt <= CW'(1); req_q <= sample_num;
    end else if (st == S_HAND) begin
      if (hdr_ready) begin st <= S_IDLE; cnt <= CW'(T_IDLE); end
    end else if (!expire) begin
      cnt <= cnt - CW'(1);
    end else begin
      case (st)
        S_START: begin st <= S_REQ0; cnt <= CW'(T_START); end
        S_REQ0: begin
          drq_q <= 1'b1; st <= S_DROP; cnt <= CW'(T_DROP);
          post_st <= S_LAST; post_cnt <= CW'(T_LAST - T_DROP);
        end
        S_LAST: begin
          drq_q <= 1'b1; st <= S_DROP; cnt <= CW'(T_DROP);
          if (SW'(req_q) > SW'(data_in)) begin
            post_st <= S_IDLE; post_cnt <= CW'(T_IDLE);
          end else begin
            post_st <= S_DUM1; post_cnt <= CW'(T_DUM1 - T_DROP);
          end
        end
        S_DUM1: begin
          drq_q <= 1'b1; st <= S_DROP; cnt <= CW'(T_DROP);
          post_st <= S_AHI; post_cnt <= CW'(T_AHI - T_DROP);
        end
        S_AHI: begin
          addr_q <= AW'(data_in) << HI_POS;
          drq_q <= 1'b1; st <= S_DROP; cnt <= CW'(T_DROP);
          post_st <= S_ALO; post_cnt <= CW'(T_ALO - T_DROP);
        end
        S_ALO: begin
          addr_q <= addr_q | (AW'(data_in) << 1);
          drq_q <= 1'b1; st <= S_DROP; cnt <= CW'(T_DROP);
          post_st <= S_DUM2; post_cnt <= CW'(T_DUM2 - T_DROP);
        end
        S_DUM2: begin
          addr_q <= addr_q + AW'(1);
          drq_q <= 1'b1; st <= S_DROP; cnt <= CW'(T_DROP);
          post_st <= S_HAND; post_cnt <= CW'(1);
        end
        S_DROP: begin
          drq_q <= 1'b0; st <= post_st; cnt <= post_cnt;
        end
        default: cnt <= CW'(T_IDLE);
      endcase
    end
  end

  // R1: reset forces the idle view at the ports
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> busy_n && !drq && !hdr_valid);
  // R2: a rising start seen while idle always leaves idle
  a_r2_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start) && busy_n |=> !busy_n);
  // R6: no request is ever pending while idle
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    busy_n |-> !drq);
  // R9: the offered address holds until taken
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_ready |=> hdr_valid && $stable(fetch_addr));
  // R9: handoff returns to idle
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_ready |=> busy_n && !hdr_valid);
  // R5: no request while the address is on offer
  a_r5_no_req_at_hand: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> !drq);
endmodule

// File: tb/tb_adpcm_fetch_seq.sv
`timescale 1ns/1ps
module tb_adpcm_fetch_seq;
  logic clk = 0, rst_n = 0, start = 0, hdr_ready = 0;
  logic [7:0] sample_num = 0, data_in = 0;
  logic drq, busy_n, hdr_valid;
  logic [16:0] fetch_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  adpcm_fetch_seq dut (.clk(clk), .rst_n(rst_n), .start(start), .sample_num(sample_num),
    .data_in(data_in), .drq(drq), .busy_n(busy_n), .fetch_addr(fetch_addr),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [16:0] exp_addr(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo, 1'b0} + 17'd1;
  endfunction

  task automatic play(input logic [7:0] num, input logic [7:0] last, input logic [7:0] hi,
                      input logic [7:0] lo, input int rdy_wait, input bit collide);
    int t, idx, rise_t;
    bit prev, abort;
    int exp_rise[6];
    logic [7:0] bytes[5];
    exp_rise = '{72, 116, 144, 176, 220, 256};
    bytes = '{last, 8'($urandom), hi, lo, 8'($urandom)};
    abort = num > last;
    t = 0; idx = 0; rise_t = 0; prev = 0;
    @(negedge clk);
    sample_num = num; start = 1;
    while (t < 400) begin
      @(negedge clk); t++;
      if (t == 2) chk(busy_n == 0, "R3 busy after take", busy_n, 0);
      if (t == 3) begin start = 0; sample_num = ~num; end  // R10
      if (drq && !prev) begin
        if (idx < 6) chk(t == exp_rise[idx], idx == 0 ? "R4 first request" : "R5 request spacing", t, exp_rise[idx]);
        rise_t = t;
        if (idx < 5) data_in = bytes[idx];
        idx++;
      end
      if (!drq && prev) chk(t - rise_t == 21, "R6 pulse width", t - rise_t, 21);
      prev = drq;
      if (abort && busy_n) break;
      if (hdr_valid) break;
    end
    if (abort) begin
      chk(t == 137, "R7 abort time", t, 137);
      chk(idx == 2, "R7 request count", idx, 2);
      chk(!hdr_valid, "R7 no handoff", hdr_valid, 0);
    end else begin
      chk(t == 277, "R9 valid time", t, 277);
      chk(idx == 6, "R5 request count", idx, 6);
      chk(fetch_addr == exp_addr(hi, lo), "R8 address R10", fetch_addr, exp_addr(hi, lo));
      for (int i = 0; i < rdy_wait; i++) begin
        @(negedge clk);
        chk(hdr_valid && fetch_addr == exp_addr(hi, lo), "R9 hold", fetch_addr, exp_addr(hi, lo));
      end
      hdr_ready = 1;
      if (collide) start = 1;
      @(negedge clk);
      hdr_ready = 0;
      chk(busy_n && !hdr_valid, "R9 release", busy_n, 1);
      if (collide) begin
        repeat (5) @(negedge clk);
        chk(busy_n && !drq, "R2 start at handoff ignored", busy_n, 1);
        start = 0;
      end
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    start = 1;
    repeat (3) @(negedge clk);
    chk(busy_n && !drq && !hdr_valid && fetch_addr == 0, "R1 reset state", fetch_addr, 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk(busy_n == 1, "R2 held start ignored", busy_n, 1);
    start = 0;
    @(negedge clk);
    play(8'd5, 8'd5, 8'hFF, 8'hFF, 2, 1);
    play(8'd6, 8'd5, 8'h12, 8'h34, 0, 0);
    play(8'd0, 8'd0, 8'h00, 8'h00, 0, 0);
    play(8'd255, 8'd254, 8'h01, 8'h01, 0, 0);
    for (int r = 0; r < 10; r++) begin
      logic [7:0] l, n;
      l = 8'($urandom);
      n = ($urandom % 2) ? 8'($urandom % (int'(l) + 1)) : 8'($urandom);
      play(n, l, 8'($urandom), 8'($urandom), $urandom % 4, r % 3 == 0);
    end
    @(negedge clk);
    sample_num = 8'd1; start = 1;
    repeat (100) @(negedge clk);
    start = 0; rst_n = 0;
    @(negedge clk);
    chk(busy_n && !drq && !hdr_valid, "R11 mid reset", busy_n, 1);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(busy_n && !drq, "R11 stays idle", busy_n, 1);
    play(8'd3, 8'd9, 8'hA5, 8'h5A, 1, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule